// File: doc/BRIEF.md
# Nested Priority Interrupt Channel

This block arbitrates one class of interrupts for a CPU. It is instantiated once per class, for example once for normal interrupts and once for fast interrupts. Each of N level-sensitive request lines carries its own 4-bit urgency code. The block picks the most urgent pending line and raises a request to the CPU. It also presents that line's number and urgency code on registered outputs.

When the CPU accepts the request, it sends a one-cycle acknowledge. The presented winner then becomes the active interrupt. A one-cycle completion pulse retires the active interrupt. While an interrupt is active, only strictly more urgent lines can compete. If such a line is acknowledged, the interrupted entry is saved on an internal last-in-first-out store. A later completion brings back that entry's number and urgency code and nothing else. Bus decoding, vector tables, enables and source clearing belong to the surrounding logic.

Top module: `npic_channel`

## Requirements
- R1: Each line i owns the 4-bit field `prio_i[4*i+3:4*i]`. Value 0 is the most urgent and 15 the least. Among the eligible pending lines, the one with the smallest value is presented as the winner.
- R2: When several eligible pending lines share the smallest value, the line with the lowest index wins.
- R3: `req_o` and `win_valid_o` are high exactly when an eligible pending line exists. All winner outputs reflect the inputs present at the previous rising clock edge.
- R4: An acknowledge while `win_valid_o` is high loads the presented winner's number and urgency into the active outputs at the next edge.
- R5: While an interrupt is active, a pending line whose value is equal to or larger than the active value is excluded from selection.
- R6: While an interrupt is active, a pending line with a strictly smaller value raises `req_o` again and is presented as the winner.
- R7: An acknowledge while an interrupt is already active saves the active number and urgency on the nesting store. The new winner then becomes active.
- R8: A completion while an interrupt is active restores the most recently saved entry into the active outputs. If the store is empty, the active outputs become invalid.
- R9: A restore touches only the active outputs. The winner outputs keep showing the best eligible pending line under the restored mask, and never the restored interrupt.
- R10: An acknowledge while `win_valid_o` is low has no effect.
- R11: A completion while nothing is active has no effect.
- R12: A completion and an acknowledge in the same cycle act as completion first, then acknowledge. The winner becomes active, and the saved entries are left exactly as they were.
- R13: A synchronous active-high reset clears the request, the winner and active outputs, and empties the nesting store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | N | Level-sensitive pending lines |
| prio_i | input | 4*N | Urgency code per line, 4 bits each |
| ack_i | input | 1 | Acknowledge pulse: winner becomes active |
| done_i | input | 1 | Completion pulse: retire active interrupt |
| req_o | output | 1 | Interrupt request to the CPU |
| win_valid_o | output | 1 | Winner outputs hold a valid line |
| win_id_o | output | $clog2(N) | Winning line number |
| win_prio_o | output | 4 | Winning line urgency code |
| act_valid_o | output | 1 | An interrupt is active |
| act_id_o | output | $clog2(N) | Active line number |
| act_prio_o | output | 4 | Active urgency code |

## Verification
Every result is due one rising edge after its cause. Winner and request outputs follow a change on `pend_i` or `prio_i` after one edge. Active outputs, and the winner mask derived from them, follow an acknowledge or completion after the same single edge. The bench drives all inputs on the falling edge and samples 1 ns after the next rising edge, so each comparison lands in the first cycle in which the new value is due. Arithmetic sweeps and a reference of the nesting order supply the expected values.

// File: rtl/npic_pkg.sv
package npic_pkg;
  localparam int PRIO_W = 4;
  localparam int LEVELS = 1 << PRIO_W;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/npic_arbiter.sv
module npic_arbiter
  import npic_pkg::*;
#(
  parameter int N   = 32,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]        pend,
  input  logic [N*PRIO_W-1:0] prio_flat,
  input  logic                lim_v,
  input  prio_t               lim_pr,
  output logic                found,
  output logic [IDW-1:0]      id,
  output prio_t               pr
);
  logic [N-1:0] elig;
  prio_t        lp [N];

  generate
    for (genvar g = 0; g < N; g++) begin : g_line
      assign lp[g]   = prio_flat[g*PRIO_W +: PRIO_W];
      assign elig[g] = pend[g] && (!lim_v || (lp[g] < lim_pr));
    end
  endgenerate

  // Scan from the top index down; "<=" lets a lower index take ties.
  always_comb begin
    found = 1'b0;
    id    = '0;
    pr    = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && (!found || (lp[i] <= pr))) begin
        found = 1'b1;
        id    = IDW'(i);
        pr    = lp[i];
      end
    end
  end
endmodule

// File: rtl/npic_stack.sv
module npic_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int AW  = $clog2(DEPTH);
  localparam int SPW = $clog2(DEPTH + 1);

  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp;

  // Storage has no reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (push) mem[AW'(sp)] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp + 1'b1;
    else if (pop)  sp <= sp - 1'b1;
  end

  assign top   = mem[AW'(sp - 1'b1)];
  assign empty = (sp == '0);
  assign full  = (sp == SPW'(DEPTH));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst) push |-> !full)
    else $error("nesting store overflow");
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst) pop |-> !empty)
    else $error("nesting store underflow");
  p_push_pop_excl_r12: assert property (@(posedge clk) disable iff (rst) !(push && pop))
    else $error("push and pop in one cycle");
endmodule

// File: rtl/npic_active.sv
module npic_active
  import npic_pkg::*;
#(
  parameter int IDW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ack,
  input  logic           done,
  input  logic           win_v,
  input  logic [IDW-1:0] win_id,
  input  prio_t          win_pr,
  input  logic [IDW-1:0] top_id,
  input  prio_t          top_pr,
  input  logic           stk_empty,
  output logic           act_v,
  output logic [IDW-1:0] act_id,
  output prio_t          act_pr,
  output logic           nxt_v,
  output logic [IDW-1:0] nxt_id,
  output prio_t          nxt_pr,
  output logic           push,
  output logic           pop
);
  logic take, fin;

  assign take = ack && win_v;
  assign fin  = done && act_v;

  always_comb begin
    nxt_v  = act_v;
    nxt_id = act_id;
    nxt_pr = act_pr;
    push   = 1'b0;
    pop    = 1'b0;
    if (fin && take) begin
      // Retire then accept: the restored entry would be pushed straight back.
      nxt_id = win_id;
      nxt_pr = win_pr;
    end else if (fin) begin
      if (!stk_empty) begin
        pop    = 1'b1;
        nxt_id = top_id;
        nxt_pr = top_pr;
      end else begin
        nxt_v  = 1'b0;
      end
    end else if (take) begin
      push   = act_v;
      nxt_v  = 1'b1;
      nxt_id = win_id;
      nxt_pr = win_pr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_v  <= 1'b0;
      act_id <= '0;
      act_pr <= '0;
    end else begin
      act_v  <= nxt_v;
      act_id <= nxt_id;
      act_pr <= nxt_pr;
    end
  end

  p_restore_r8: assert property (@(posedge clk) disable iff (rst)
      done && act_v && !ack && !stk_empty |=> act_v && act_id == $past(top_id) && act_pr == $past(top_pr))
    else $error("restore did not reload the saved entry");
  p_last_retire_r8: assert property (@(posedge clk) disable iff (rst)
      done && act_v && !ack && stk_empty |=> !act_v)
    else $error("retire with empty store left an active entry");
endmodule

// File: rtl/npic_channel.sv
module npic_channel
  import npic_pkg::*;
#(
  parameter int N     = 32,
  parameter int DEPTH = LEVELS,
  localparam int IDW  = $clog2(N),
  localparam int EW   = IDW + PRIO_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        pend_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  input  logic                ack_i,
  input  logic                done_i,
  output logic                req_o,
  output logic                win_valid_o,
  output logic [IDW-1:0]      win_id_o,
  output logic [PRIO_W-1:0]   win_prio_o,
  output logic                act_valid_o,
  output logic [IDW-1:0]      act_id_o,
  output logic [PRIO_W-1:0]   act_prio_o
);
  logic           win_v_q;
  logic [IDW-1:0] win_id_q;
  prio_t          win_pr_q;

  logic           act_v, nxt_v;
  logic [IDW-1:0] act_id, nxt_id;
  prio_t          act_pr, nxt_pr;
  logic           push, pop, stk_empty, stk_full;
  logic [EW-1:0]  top_e;

  logic           arb_found;
  logic [IDW-1:0] arb_id;
  prio_t          arb_pr;

  npic_active #(.IDW(IDW)) u_active (
    .clk(clk), .rst(rst), .ack(ack_i), .done(done_i),
    .win_v(win_v_q), .win_id(win_id_q), .win_pr(win_pr_q),
    .top_id(top_e[EW-1:PRIO_W]), .top_pr(top_e[PRIO_W-1:0]), .stk_empty(stk_empty),
    .act_v(act_v), .act_id(act_id), .act_pr(act_pr),
    .nxt_v(nxt_v), .nxt_id(nxt_id), .nxt_pr(nxt_pr),
    .push(push), .pop(pop)
  );

  npic_stack #(.DEPTH(DEPTH), .W(EW)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .wdata({act_id, act_pr}), .top(top_e), .empty(stk_empty), .full(stk_full)
  );

  // Mask against the next active state so the registered winner is never stale.
  npic_arbiter #(.N(N), .IDW(IDW)) u_arb (
    .pend(pend_i), .prio_flat(prio_i), .lim_v(nxt_v), .lim_pr(nxt_pr),
    .found(arb_found), .id(arb_id), .pr(arb_pr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_v_q  <= 1'b0;
      win_id_q <= '0;
      win_pr_q <= '0;
    end else begin
      win_v_q  <= arb_found;
      win_id_q <= arb_id;
      win_pr_q <= arb_pr;
    end
  end

  assign req_o       = win_v_q;
  assign win_valid_o = win_v_q;
  assign win_id_o    = win_id_q;
  assign win_prio_o  = win_pr_q;
  assign act_valid_o = act_v;
  assign act_id_o    = act_id;
  assign act_prio_o  = act_pr;

  p_win_beats_act_r5: assert property (@(posedge clk) disable iff (rst)
      win_valid_o && act_valid_o |-> win_prio_o < act_prio_o)
    else $error("winner not more urgent than active");
  p_ack_loads_r4: assert property (@(posedge clk) disable iff (rst)
      ack_i && win_valid_o |=> act_valid_o && act_id_o == $past(win_id_o) && act_prio_o == $past(win_prio_o))
    else $error("acknowledge did not load winner");
  p_bad_ack_r10: assert property (@(posedge clk) disable iff (rst)
      ack_i && !win_valid_o && !done_i |=> $stable(act_valid_o) && $stable(act_id_o) && $stable(act_prio_o))
    else $error("acknowledge without winner changed state");
  p_idle_done_r11: assert property (@(posedge clk) disable iff (rst)
      done_i && !act_valid_o && !ack_i |=> !act_valid_o)
    else $error("completion while idle changed state");
  p_store_room_r7: assert property (@(posedge clk) disable iff (rst) push |-> !stk_full)
    else $error("nesting deeper than store");
endmodule

// File: tb/npic_channel_tb_top.sv
module npic_channel_tb_top;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [N-1:0]   pend = '0;
  logic [4*N-1:0] prio = '1;
  logic           ack = 1'b0, done = 1'b0;
  logic           req, wv, av;
  logic [IW-1:0]  wid, aid;
  logic [3:0]     wpr, apr;

  npic_channel #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .pend_i(pend), .prio_i(prio), .ack_i(ack), .done_i(done),
    .req_o(req), .win_valid_o(wv), .win_id_o(wid), .win_prio_o(wpr),
    .act_valid_o(av), .act_id_o(aid), .act_prio_o(apr)
  );

  int checks = 0, errors = 0;
  int cyc = 0;

  // Reference state
  bit m_wv, m_av;
  int m_wid, m_wpr, m_aid, m_apr, m_sp;
  int s_id [16];
  int s_pr [16];

  task automatic chk(string tag, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
    end
  endtask

  function automatic logic [4*N-1:0] setp(logic [4*N-1:0] base, int idx, int val);
    logic [4*N-1:0] r = base;
    r[4*idx +: 4] = 4'(val);
    return r;
  endfunction

  task automatic compare(string tag);
    chk(tag, "req", int'(req), int'(m_wv));
    chk(tag, "win_valid", int'(wv), int'(m_wv));
    if (m_wv) begin
      chk(tag, "win_id", int'(wid), m_wid);
      chk(tag, "win_prio", int'(wpr), m_wpr);
    end
    chk(tag, "act_valid", int'(av), int'(m_av));
    if (m_av) begin
      chk(tag, "act_id", int'(aid), m_aid);
      chk(tag, "act_prio", int'(apr), m_apr);
    end
  endtask

  // Called at a falling edge; applies inputs, checks after the rising edge.
  task automatic step(string tag, logic [N-1:0] p, logic [4*N-1:0] pr, bit a, bit d);
    bit take, fin;
    pend = p; prio = pr; ack = a; done = d;
    @(posedge clk); #1;
    take = a && m_wv;
    fin  = d && m_av;
    if (fin) begin
      if (m_sp > 0) begin
        m_sp--; m_aid = s_id[m_sp]; m_apr = s_pr[m_sp];
      end else m_av = 0;
    end
    if (take) begin
      if (m_av) begin
        s_id[m_sp] = m_aid; s_pr[m_sp] = m_apr; m_sp++;
      end
      m_av = 1; m_aid = m_wid; m_apr = m_wpr;
    end
    m_wv = 0;
    for (int i = 0; i < N; i++) begin
      int v = int'(pr[4*i +: 4]);
      if (p[i] && (!m_av || v < m_apr) && (!m_wv || v < m_wpr)) begin
        m_wv = 1; m_wid = i; m_wpr = v;
      end
    end
    compare(tag);
    @(negedge clk);
  endtask

  task automatic do_reset(string tag);
    rst = 1'b1; pend = '0; ack = 0; done = 0;
    @(posedge clk); @(posedge clk); #1;
    m_wv = 0; m_av = 0; m_sp = 0;
    chk(tag, "req", int'(req), 0);
    chk(tag, "win_valid", int'(wv), 0);
    chk(tag, "act_valid", int'(av), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4*N-1:0] base;
    @(negedge clk);
    do_reset("R13");

    // R1 and R2: sweep two competing lines over every urgency pair
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        base = setp(setp('1, 2, a), 5, b);
        step((a == b) ? "R2" : "R1", 8'b0010_0100, base, 0, 0);
      end
    end
    // R2: all lines pending at one shared value
    step("R2", 8'hFF, {8{4'd7}}, 0, 0);
    // R3: no pending lines drops the request
    step("R3", 8'h00, '1, 0, 0);
    // R10: acknowledge with no winner
    step("R10", 8'h00, '1, 1, 0);
    // R11: completion with nothing active
    step("R11", 8'h00, '1, 0, 1);

    // R4: acknowledge loads the winner
    base = setp('1, 3, 6);
    step("R4", 8'b0000_1000, base, 0, 0);
    step("R4", 8'b0000_1000, base, 1, 0);
    // R5: equal and less urgent lines are masked
    base = setp(setp(base, 1, 6), 4, 9);
    step("R5", 8'b0001_1010, base, 0, 0);
    // R6: a more urgent line raises the request again
    base = setp(base, 6, 2);
    step("R6", 8'b0101_1010, base, 0, 0);
    // R7: nested acknowledges save the interrupted entries
    step("R7", 8'b0101_1010, base, 1, 0);
    base = setp(base, 0, 0);
    step("R7", 8'b0101_1011, base, 0, 0);
    step("R7", 8'b0101_1011, base, 1, 0);
    // R9: restore of 6/2; line 6 still pending stays masked, not re-presented
    step("R9", 8'b0101_0000, base, 0, 1);
    // R8: restore of 3/6, then retire with an empty store
    step("R8", 8'b0101_0000, base, 0, 1);
    step("R8", 8'b0000_0000, base, 1, 0);
    step("R8", 8'b0000_0000, base, 0, 1);
    step("R8", 8'b0000_0000, base, 0, 1);

    // R12: completion and acknowledge in the same cycle
    base = setp(setp(setp('1, 5, 8), 2, 3), 7, 1);
    step("R12", 8'b0010_0000, base, 0, 0);
    step("R12", 8'b0010_0000, base, 1, 0);
    step("R12", 8'b0000_0100, base, 0, 0);
    step("R12", 8'b0000_0100, base, 1, 0);
    step("R12", 8'b1000_0000, base, 0, 0);
    step("R12", 8'b1000_0000, base, 1, 1);
    step("R12", 8'b0000_0000, base, 0, 1);
    step("R12", 8'b0000_0000, base, 0, 1);
    step("R12", 8'b0000_0000, base, 0, 1);

    // R7 with R8: random nesting traffic against the reference
    for (int k = 0; k < 4000; k++) begin
      logic [4*N-1:0] rp;
      for (int i = 0; i < N; i++) rp[4*i +: 4] = 4'($urandom_range(0, 15));
      step("R7", 8'($urandom), rp, ($urandom_range(0, 9) < 4), ($urandom_range(0, 9) < 3));
    end

    // R13: reset in the middle of activity
    do_reset("R13");
    step("R13", 8'h00, '1, 0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule